// File: doc/BRIEF.md
# Versioned NVM Write Command Sequencer

This block runs on the programmer side of a non-volatile memory link. It drives a register-mapped memory controller through a byte-wide bus master port with address, write data, write strobe, read strobe, read data and a ready handshake. A request carries the controller version (0, 2, 3, 4 or 5), a command code, a region flag (flash or EEPROM), a start address and a byte count. The payload bytes arrive on a data input, and the block takes one per store. The block checks the request, then issues the stores, the command writes and the status reads in the order that the version requires. It ends with a one-cycle done or error pulse.

The five versions form three orderings. Version 0 fills the buffer first and sends the command last. Versions 2 and 4 send the command first and close with a no-operation write. Versions 3 and 5 clear the controller, fill the buffer, then send the command. Only one request is in flight at a time. While a request is being worked, the request-ready output is low.

Top module: `nvm_wr_seq`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the cycle after the done or error pulse.
- R2: Version 0 stores every byte to `{8'h00, (addr+i)[15:0]}`. It then writes the command to `CTRL_BASE+0`, then reads `CTRL_BASE+2` until idle. It issues no stop write.
- R3: Versions 2 and 4 write the command to `CTRL_BASE+0`, then store the bytes, then read status until idle, then write 0x00 to `CTRL_BASE+0`. Status is at `CTRL_BASE+2` for version 2 and at `CTRL_BASE+6` for version 4.
- R4: Versions 3 and 5 write 0x00 to `CTRL_BASE+0`, then store the bytes, then write the command to `CTRL_BASE+0`, then read `CTRL_BASE+6` until idle. They issue no stop write.
- R5: For versions 2 to 5, a store goes to bus address bit 23 equal to the region flag (1 for flash), with bits 22:0 equal to `addr+i`. For version 0, the region flag and address bits above 15 are ignored.
- R6: A flash request with an odd start address or an odd byte count is rejected with `err_code`=1 and causes no bus traffic. An EEPROM request of odd length is accepted.
- R7: A request is rejected with code 1 and no bus traffic if its length is zero or its version is 1, 6 or 7. For versions 3 and 5 it is also rejected if `(addr mod B)+len > B`, where B is 128 for flash and 8 for EEPROM.
- R8: A status read whose low nibble is non-zero means the controller is busy, and the read is repeated. A read whose low nibble is zero ends polling. Success gives a done pulse with `err_code`=0.
- R9: If the high nibble of the final status read is non-zero, it is copied to `stat_err` and the request ends with `err_code`=3. Versions 2 and 4 still issue the stop write first.
- R10: If polling lasts `poll_limit` cycles without an idle status, the request aborts with `err_code`=2. No further writes follow.
- R11: The state register is one-hot, and the write and read strobes are never both high.
- R12: `dat_take` is high for exactly one cycle per completed data store. Over a request it pulses exactly `len` times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_ver | input | 3 | Controller version |
| req_flash | input | 1 | Region: 1 flash, 0 EEPROM |
| req_cmd | input | 8 | Command code written to the control register |
| req_addr | input | 23 | Byte address within the region |
| req_len | input | 9 | Byte count |
| dat_byte | input | 8 | Current payload byte |
| dat_take | output | 1 | Current payload byte consumed |
| poll_limit | input | 16 | Polling cycle limit |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_we | output | 1 | Bus write strobe |
| bus_re | output | 1 | Bus read strobe |
| bus_rdata | input | 8 | Bus read data |
| bus_rdy | input | 1 | Bus beat completes this cycle |
| done | output | 1 | Request finished cleanly (pulse) |
| err | output | 1 | Request failed (pulse) |
| err_code | output | 2 | 0 none, 1 rejected, 2 timeout, 3 controller error |
| stat_err | output | 4 | Error nibble from the final status read |

## Verification
A wrong ordering state shows up at once on the bus. The first beat that goes to the wrong register, or carries the wrong value, differs from the scoreboard entry for that position. A wrong byte index shows up one store later as a wrong address or data byte. A skipped or extra stop write appears as a surplus or missing beat when the done or error pulse arrives. A broken validity check shows up as bus traffic on a request that should have been refused, or as a rejection code where a sequence was expected. Stalls on the ready line check that no state advances without a completed beat.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    localparam int ADDR_W = 24;
    localparam int OFF_W  = ADDR_W - 1;
    localparam int LEN_W  = 9;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] NOOP_CMD = 8'h00;

    typedef enum logic [7:0] {
        S_IDLE = 8'h01,
        S_PRE  = 8'h02,
        S_FILL = 8'h04,
        S_CMD  = 8'h08,
        S_POLL = 8'h10,
        S_STOP = 8'h20,
        S_DONE = 8'h40,
        S_ERR  = 8'h80
    } seq_state_e;

    typedef enum logic [1:0] {
        E_NONE    = 2'd0,
        E_REJECT  = 2'd1,
        E_TIMEOUT = 2'd2,
        E_CTRL    = 2'd3
    } fail_e;

    // three bus orderings shared by the five versions
    typedef enum logic [1:0] {
        FLOW_BUF_LAST    = 2'd0,
        FLOW_CMD_FIRST   = 2'd1,
        FLOW_CLEAR_FIRST = 2'd2,
        FLOW_NONE        = 2'd3
    } flow_e;

    typedef struct packed {
        logic [2:0]        ver;
        logic              flash;
        logic [BYTE_W-1:0] cmd;
        logic [OFF_W-1:0]  addr;
        logic [LEN_W-1:0]  len;
    } nvm_req_t;

    function automatic flow_e flow_of(input logic [2:0] v);
        case (v)
            3'd0:       return FLOW_BUF_LAST;
            3'd2, 3'd4: return FLOW_CMD_FIRST;
            3'd3, 3'd5: return FLOW_CLEAR_FIRST;
            default:    return FLOW_NONE;
        endcase
    endfunction

    function automatic logic [3:0] status_off(input logic [2:0] v);
        return (v == 3'd0 || v == 3'd2) ? 4'd2 : 4'd6;
    endfunction

    function automatic logic stat_busy(input logic [BYTE_W-1:0] s);
        return |s[3:0];
    endfunction

    function automatic logic [3:0] stat_fault(input logic [BYTE_W-1:0] s);
        return s[7:4];
    endfunction

endpackage

// File: rtl/nvm_req_check.sv
module nvm_req_check
    import nvm_seq_pkg::*;
#(
    parameter int FLASH_BUF = 128,
    parameter int EE_BUF    = 8
) (
    input  logic [2:0]                   ver,
    input  logic                         flash,
    input  logic [$clog2(FLASH_BUF)-1:0] addr_lo,
    input  logic [LEN_W-1:0]             len,
    output logic                         ok
);
    localparam int FB_W  = $clog2(FLASH_BUF);
    localparam int EB_W  = $clog2(EE_BUF);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] fill_end;
    logic [SUM_W-1:0] buf_lim;
    logic             ver_ok, len_ok, align_ok, fit_ok, paged;

    always_comb begin
        if (flash) begin
            fill_end = SUM_W'(addr_lo) + SUM_W'(len);
            buf_lim  = SUM_W'(FLASH_BUF);
        end else begin
            fill_end = SUM_W'(addr_lo[EB_W-1:0]) + SUM_W'(len);
            buf_lim  = SUM_W'(EE_BUF);
        end
    end

    assign ver_ok   = (flow_of(ver) != FLOW_NONE);
    assign paged    = (flow_of(ver) == FLOW_CLEAR_FIRST);
    assign len_ok   = (len != '0);
    assign align_ok = !flash || (!addr_lo[0] && !len[0]);
    assign fit_ok   = !paged || (fill_end <= buf_lim);
    assign ok       = ver_ok && len_ok && align_ok && fit_ok;

    initial begin
        if (FB_W < EB_W) $error("flash buffer must not be smaller than EEPROM buffer");
    end
endmodule

// File: rtl/nvm_poll_timer.sv
module nvm_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt >= limit);
endmodule

// File: rtl/nvm_wr_seq.sv
module nvm_wr_seq
    import nvm_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_BASE = 24'h001000,
    parameter int                FLASH_BUF = 128,
    parameter int                EE_BUF    = 8,
    parameter int                TMR_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_ver,
    input  logic              req_flash,
    input  logic [7:0]        req_cmd,
    input  logic [OFF_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        dat_byte,
    output logic              dat_take,
    input  logic [TMR_W-1:0]  poll_limit,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_rdy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic [3:0]        stat_err
);
    localparam int AW   = ADDR_W;
    localparam int LW   = LEN_W;
    localparam int FB_W = $clog2(FLASH_BUF);

    seq_state_e       st, st_nx;
    nvm_req_t         rq;
    flow_e            fl;
    logic [LW-1:0]    idx;
    fail_e            code_q;
    logic [3:0]       serr_q;
    logic             req_ok, tmo, hs, poll_fin, last_byte;
    logic [OFF_W-1:0] sum;
    logic [AW-1:0]    tgt;

    nvm_req_check #(.FLASH_BUF(FLASH_BUF), .EE_BUF(EE_BUF)) u_chk (
        .ver     (req_ver),
        .flash   (req_flash),
        .addr_lo (req_addr[FB_W-1:0]),
        .len     (req_len),
        .ok      (req_ok)
    );

    nvm_poll_timer #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (st == S_POLL),
        .limit   (poll_limit),
        .expired (tmo)
    );

    assign fl        = flow_of(rq.ver);
    assign req_ready = (st == S_IDLE);
    assign hs        = req_valid && req_ready;
    assign poll_fin  = (st == S_POLL) && bus_rdy && !stat_busy(bus_rdata);
    assign last_byte = (idx == rq.len - 1'b1);
    assign sum       = rq.addr + OFF_W'(idx);
    assign tgt       = (rq.ver == 3'd0) ? {{(AW-16){1'b0}}, sum[15:0]}
                                        : {rq.flash, sum};

    // bus beat presented in each state
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = CTRL_BASE;
        bus_wdata = NOOP_CMD;
        case (st)
            S_PRE, S_STOP: bus_we = 1'b1;
            S_CMD: begin
                bus_we    = 1'b1;
                bus_wdata = rq.cmd;
            end
            S_FILL: begin
                bus_we    = 1'b1;
                bus_addr  = tgt;
                bus_wdata = dat_byte;
            end
            S_POLL: begin
                bus_re   = 1'b1;
                bus_addr = CTRL_BASE + AW'(status_off(rq.ver));
            end
            default: ;
        endcase
    end

    assign dat_take = (st == S_FILL) && bus_rdy;

    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE: if (hs) begin
                if (!req_ok) st_nx = S_ERR;
                else case (flow_of(req_ver))
                    FLOW_BUF_LAST:  st_nx = S_FILL;
                    FLOW_CMD_FIRST: st_nx = S_CMD;
                    default:        st_nx = S_PRE;
                endcase
            end
            S_PRE:  if (bus_rdy) st_nx = S_FILL;
            S_FILL: if (bus_rdy && last_byte)
                        st_nx = (fl == FLOW_CMD_FIRST) ? S_POLL : S_CMD;
            S_CMD:  if (bus_rdy)
                        st_nx = (fl == FLOW_CMD_FIRST) ? S_FILL : S_POLL;
            S_POLL: begin
                if (poll_fin) begin
                    if (fl == FLOW_CMD_FIRST)                st_nx = S_STOP;
                    else if (stat_fault(bus_rdata) != 4'h0)  st_nx = S_ERR;
                    else                                     st_nx = S_DONE;
                end else if (tmo) begin
                    st_nx = S_ERR;
                end
            end
            S_STOP: if (bus_rdy) st_nx = (serr_q != 4'h0) ? S_ERR : S_DONE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            rq     <= '0;
            idx    <= '0;
            code_q <= E_NONE;
            serr_q <= '0;
        end else begin
            st <= st_nx;
            if (hs) begin
                rq     <= '{ver: req_ver, flash: req_flash, cmd: req_cmd,
                            addr: req_addr, len: req_len};
                code_q <= req_ok ? E_NONE : E_REJECT;
                serr_q <= '0;
                idx    <= '0;
            end
            if (st == S_FILL && bus_rdy) idx <= last_byte ? '0 : idx + 1'b1;
            if (poll_fin) begin
                serr_q <= stat_fault(bus_rdata);
                if (stat_fault(bus_rdata) != 4'h0) code_q <= E_CTRL;
            end else if (st == S_POLL && tmo) begin
                code_q <= E_TIMEOUT;
            end
        end
    end

    assign done     = (st == S_DONE);
    assign err      = (st == S_ERR);
    assign err_code = code_q;
    assign stat_err = serr_q;

    // R11
    state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(st) == 1);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));
    // R1
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        hs |=> !req_ready);
    // R6
    reject_path_chk: assert property (@(posedge clk) disable iff (rst)
        (hs && !req_ok) |=> (err && err_code == E_REJECT && !bus_we && !bus_re));
    // R10
    tmo_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_POLL && tmo && !poll_fin) |=> (err && err_code == E_TIMEOUT));
    // R9
    ctrl_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (err && err_code == E_CTRL) |-> stat_err != 4'h0);
    // R8
    done_clean_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (err_code == E_NONE && stat_err == 4'h0));
    // R12
    take_store_chk: assert property (@(posedge clk) disable iff (rst)
        dat_take |-> (bus_we && bus_addr != CTRL_BASE));
endmodule

// File: tb/tb_nvm_wr_seq.sv
module tb_nvm_wr_seq;
    import nvm_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_flash;
    logic [2:0]  req_ver;
    logic [7:0]  req_cmd;
    logic [22:0] req_addr;
    logic [8:0]  req_len;
    logic [7:0]  dat_byte;
    logic        dat_take;
    logic [15:0] poll_limit;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        bus_we, bus_re, bus_rdy;
    logic        done, err;
    logic [1:0]  err_code;
    logic [3:0]  stat_err;

    always #5 clk = ~clk;

    nvm_wr_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ver(req_ver), .req_flash(req_flash), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .dat_byte(dat_byte),
        .dat_take(dat_take), .poll_limit(poll_limit), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .done(done), .err(err),
        .err_code(err_code), .stat_err(stat_err)
    );

    typedef struct {
        bit          rd;
        logic [23:0] a;
        logic [7:0]  d;
    } beat_t;

    localparam logic [23:0] BASE = 24'h001000;

    beat_t      exp_q[$];
    int         total = 0, bad = 0;
    string      tag = "R1";
    bit         loose_rd = 1'b0, stall_on = 1'b0;
    int         busy_left = 0, didx = 0, takes = 0, cyc = 0;
    logic [3:0] serr_val = 4'h0;
    logic [7:0] mem [256];

    assign dat_byte = mem[didx[7:0]];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic push_w(input logic [23:0] a, input logic [7:0] d);
        beat_t b;
        b.rd = 1'b0; b.a = a; b.d = d;
        exp_q.push_back(b);
    endtask

    task automatic push_r(input logic [23:0] a);
        beat_t b;
        b.rd = 1'b1; b.a = a; b.d = 8'h00;
        exp_q.push_back(b);
    endtask

    // behavioural controller and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        bus_rdy   = stall_on ? ((cyc % 3) != 1) : 1'b1;
        bus_rdata = (busy_left > 0) ? 8'h01 : {serr_val, 4'h0};
        #1;
        if (!rst && (bus_we || bus_re) && bus_rdy) begin
            check(!(bus_we && bus_re), "R11", "strobes both high", {30'd0, bus_we, bus_re}, 32'd2);
            if (bus_re && loose_rd) begin
                // polling of unknown length during a timeout run
            end else if (exp_q.size() == 0) begin
                check(1'b0, tag, "unexpected bus beat", {bus_addr, bus_wdata}, 32'd0);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check(e.rd == bus_re && e.a == bus_addr && (e.rd || e.d == bus_wdata),
                      tag, "bus beat", {bus_re ? 8'hAA : 8'h00, bus_addr[15:0], bus_wdata},
                      {e.rd ? 8'hAA : 8'h00, e.a[15:0], e.d});
                check(e.a[23] == bus_addr[23], tag, "region bit", {31'd0, bus_addr[23]}, {31'd0, e.a[23]});
            end
            if (bus_re && busy_left > 0) busy_left--;
            if (dat_take) begin
                takes++;
                didx++;
            end
        end
    end

    task automatic run_req(input string t, input int ver, input bit fl, input logic [7:0] cmd,
                           input logic [22:0] a, input int len, input int busy,
                           input logic [3:0] se, input logic [1:0] ecode, input bit tmo,
                           input bit stall);
        int n;
        logic [23:0] tg;
        logic [3:0] soff;
        @(negedge clk);
        tag = t; stall_on = stall; loose_rd = tmo; serr_val = se;
        busy_left = tmo ? 1000000 : busy;
        didx = 0; takes = 0;
        poll_limit = tmo ? 16'd10 : 16'd1000;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + ver * 16 + 3);
        soff = (ver == 0 || ver == 2) ? 4'd2 : 4'd6;
        if (ecode != 2'd1) begin
            if (ver == 3 || ver == 5) push_w(BASE, 8'h00);
            if (ver == 2 || ver == 4) push_w(BASE, cmd);
            for (int i = 0; i < len; i++) begin
                tg = (ver == 0) ? {8'h00, 16'(a + 23'(i))} : {fl, 23'(a + 23'(i))};
                push_w(tg, mem[i]);
            end
            if (!(ver == 2 || ver == 4)) push_w(BASE, cmd);
            if (!tmo) begin
                for (int i = 0; i <= busy; i++) push_r(BASE + 24'(soff));
                if (ver == 2 || ver == 4) push_w(BASE, 8'h00);
            end
        end
        check(req_ready == 1'b1, "R1", "ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_ver = 3'(ver); req_flash = fl; req_cmd = cmd;
        req_addr = a; req_len = 9'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1", "ready after accept", {31'd0, req_ready}, 32'd0);
        n = 0;
        while (!(done || err) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done == (ecode == 2'd0), t, "done pulse", {31'd0, done}, {31'd0, ecode == 2'd0});
        check(err == (ecode != 2'd0), t, "err pulse", {31'd0, err}, {31'd0, ecode != 2'd0});
        check(err_code == ecode, t, "err_code", {30'd0, err_code}, {30'd0, ecode});
        check(stat_err == ((ecode == 2'd3) ? se : 4'h0), t, "stat_err", {28'd0, stat_err},
              {28'd0, (ecode == 2'd3) ? se : 4'h0});
        check(req_ready == 1'b0, "R1", "ready during end pulse", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        #2;
        check(req_ready == 1'b1, "R1", "ready after end pulse", {31'd0, req_ready}, 32'd1);
        check(exp_q.size() == 0, t, "leftover expected beats", exp_q.size(), 32'd0);
        check(takes == ((ecode == 2'd1) ? 0 : len), "R12", "dat_take count", takes,
              (ecode == 2'd1) ? 0 : len);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_ver = 3'd0; req_flash = 1'b0;
        req_cmd = 8'h00; req_addr = '0; req_len = '0; poll_limit = 16'd1000;
        bus_rdy = 1'b1; bus_rdata = 8'h00;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && !bus_we && !bus_re, "R1", "reset idle",
              {29'd0, req_ready, bus_we, bus_re}, 32'd4);
        check(err_code == 2'd0 && !done && !err, "R1", "reset status",
              {28'd0, err_code, done, err}, 32'd0);
        rst = 1'b0;
        // orderings
        run_req("R2", 0, 1'b1, 8'h03, 23'h128010, 6, 2, 4'h0, 2'd0, 1'b0, 1'b0);
        run_req("R3 R5", 2, 1'b1, 8'h02, 23'h004020, 4, 1, 4'h0, 2'd0, 1'b0, 1'b1);
        run_req("R3 R5", 4, 1'b0, 8'h13, 23'h001400, 4, 0, 4'h0, 2'd0, 1'b0, 1'b0);
        run_req("R4", 3, 1'b1, 8'h04, 23'h000100, 8, 3, 4'h0, 2'd0, 1'b0, 1'b1);
        run_req("R4", 5, 1'b0, 8'h15, 23'h001404, 4, 1, 4'h0, 2'd0, 1'b0, 1'b0);
        run_req("R7", 3, 1'b1, 8'h04, 23'h000200, 128, 0, 4'h0, 2'd0, 1'b0, 1'b0);
        run_req("R6", 0, 1'b0, 8'h03, 23'h000801, 1, 1, 4'h0, 2'd0, 1'b0, 1'b1);
        run_req("R8", 2, 1'b0, 8'h13, 23'h001402, 2, 5, 4'h0, 2'd0, 1'b0, 1'b1);
        // rejections
        run_req("R7", 3, 1'b0, 8'h13, 23'h001405, 4, 0, 4'h0, 2'd1, 1'b0, 1'b0);
        run_req("R7", 5, 1'b1, 8'h04, 23'h000000, 130, 0, 4'h0, 2'd1, 1'b0, 1'b0);
        run_req("R6", 2, 1'b1, 8'h02, 23'h004021, 4, 0, 4'h0, 2'd1, 1'b0, 1'b0);
        run_req("R6", 0, 1'b1, 8'h03, 23'h008000, 3, 0, 4'h0, 2'd1, 1'b0, 1'b0);
        run_req("R7", 2, 1'b0, 8'h13, 23'h001400, 0, 0, 4'h0, 2'd1, 1'b0, 1'b0);
        run_req("R7", 1, 1'b0, 8'h13, 23'h001400, 2, 0, 4'h0, 2'd1, 1'b0, 1'b0);
        // controller faults and timeout
        run_req("R9", 2, 1'b1, 8'h02, 23'h004000, 2, 1, 4'h5, 2'd3, 1'b0, 1'b0);
        run_req("R9", 3, 1'b0, 8'h13, 23'h001400, 2, 2, 4'hA, 2'd3, 1'b0, 1'b1);
        run_req("R10", 2, 1'b1, 8'h02, 23'h004000, 4, 0, 4'h0, 2'd2, 1'b1, 1'b0);
        run_req("R10", 0, 1'b0, 8'h03, 23'h001400, 2, 0, 4'h0, 2'd2, 1'b1, 1'b1);
        // clean request after the abort
        run_req("R3", 4, 1'b1, 8'h02, 23'h000040, 2, 0, 4'h0, 2'd0, 1'b0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule